// File: doc/BRIEF.md
# PLL Power-Up Sequencer

This block owns the mode control word of a phase-locked loop and brings the loop up and down in a safe order. Software, or a neighbouring controller, asks for power-up or power-down with single-cycle requests. The sequencer then releases the bypass, waits a settle gap counted in microsecond ticks, releases the loop reset, waits for lock and finally opens the output gate. The three control pins are driven straight from the low bits of the mode word, so the pins and the stored word always agree.

Lock can be awaited in two ways, chosen by a select input. In the timed variant a fixed number of ticks is counted. In the polled variant the lock status bit is sampled once per tick, and a sticky timeout error is raised if the check limit runs out. When the external voting machine has been handed control through the vote-enable bit, both request kinds are left alone. A plain write port loads the whole word whenever no sequence is running. The upper fields (lock count, bias count, vote reset) are stored exactly as written.

Top module: `pll_pwr_seq`

## Requirements
- R1: After synchronous reset the mode word is all zero; `bypassN`, `resetN`, `outEn`, `busy` and `timeoutErr` are all low. Mode bit 0 is the output gate, bit 1 is the active-low bypass and bit 2 is the active-low loop reset, and the three pins mirror those bits.
- R2: An accepted power-up request sets bit 1 and raises `busy` on the clock edge that samples the request. Bit 2 is set only after bit 1, and bit 0 only after bit 2.
- R3: Bit 2 is set on the edge that samples the 10th `usTick` after acceptance (SETTLE_US), and not on any earlier edge.
- R4: With `lockPollSel` low, bit 0 is set and `busy` falls on the edge that samples the 50th tick after bit 2 was set (LOCK_US). `lockIn` has no effect in this variant.
- R5: With `lockPollSel` high, bit 0 is set and `busy` falls on the first tick edge at which `lockIn` is sampled high.
- R6: With `lockPollSel` high, if `lockIn` is low on 200 consecutive ticks (POLL_MAX), then on the 200th tick edge `timeoutErr` rises and `busy` falls. Bit 0 stays low and bits 1 and 2 stay high.
- R7: A power-up request is ignored when bits 2:0 are already all ones, or when the vote-enable bit (bit 20) is set.
- R8: An accepted power-down request clears bits 2:0 together on one edge and leaves every other bit unchanged. It is ignored when bit 20 is set. If both requests arrive in the same cycle, the power-down request wins.
- R9: When idle, `wrEn` loads `wrData` into the whole mode word on the next edge, and any request in that same cycle is dropped. While `busy` is high, writes and requests are ignored.
- R10: `timeoutErr` is sticky. It is cleared by the next accepted request or by synchronous reset.
- R11: The lock count (bits 13:8), the bias count (bits 19:14) and the vote reset (bit 21) keep their written values through a full power-up and a power-down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enReq | input | 1 | Power-up request, single cycle |
| disReq | input | 1 | Power-down request, single cycle |
| usTick | input | 1 | One-cycle pulse each microsecond |
| lockIn | input | 1 | Lock status from the loop |
| lockPollSel | input | 1 | 1 selects the polled lock wait, 0 the timed wait |
| wrEn | input | 1 | Mode word write strobe |
| wrData | input | 22 | Mode word write data |
| modeWord | output | 22 | Current mode word |
| bypassN | output | 1 | Active-low bypass (mode bit 1) |
| resetN | output | 1 | Active-low loop reset (mode bit 2) |
| outEn | output | 1 | Output gate (mode bit 0) |
| busy | output | 1 | Sequence in progress |
| timeoutErr | output | 1 | Sticky lock timeout flag |

## Verification
Every result is registered once. A request or write shows its effect on the first edge that samples it, and each timed step lands on the edge that samples the counted tick. The bench changes inputs on falling edges and reads outputs on the next falling edge, one register stage after the stimulus. Ticks are issued one at a time, so each boundary can be checked one tick early (no change yet) and at the exact tick (change present). Phase 10 or 50, and check 199 or 200, are probed this way.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  localparam int MODE_W      = 22;
  localparam int BIT_OUT     = 0;
  localparam int BIT_BYP     = 1;
  localparam int BIT_RST     = 2;
  localparam int BIT_VOTE_EN = 20;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_LOCK   = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic relBypass;
    logic relReset;
    logic openOut;
    logic shutDown;
    logic cntClr;
    logic cntInc;
    logic errSet;
    logic errClr;
  } seqStrobe_t;

endpackage

// File: rtl/pll_seq_dp.sv
module pll_seq_dp
  import pll_seq_pkg::*;
#(
  parameter int SETTLE_US = 10,
  parameter int LOCK_US   = 50,
  parameter int POLL_MAX  = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        stb,
  input  logic [MODE_W-1:0] wrData,
  output logic [MODE_W-1:0] modeQ,
  output logic              errQ,
  output logic              allOn,
  output logic              voteOn,
  output logic              settleHit,
  output logic              lockHit,
  output logic              pollHit
);

  localparam int MAX_A = (SETTLE_US > LOCK_US) ? SETTLE_US : LOCK_US;
  localparam int MAX_V = (MAX_A > POLL_MAX) ? MAX_A : POLL_MAX;
  localparam int CNT_W = $clog2(MAX_V + 1);

  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ <= '0;
    end else if (stb.load) begin
      modeQ <= wrData;
    end else begin
      if (stb.shutDown) begin
        modeQ[BIT_OUT] <= 1'b0;
        modeQ[BIT_BYP] <= 1'b0;
        modeQ[BIT_RST] <= 1'b0;
      end
      if (stb.relBypass) modeQ[BIT_BYP] <= 1'b1;
      if (stb.relReset)  modeQ[BIT_RST] <= 1'b1;
      if (stb.openOut)   modeQ[BIT_OUT] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || stb.cntClr) cntQ <= '0;
    else if (stb.cntInc)   cntQ <= cntQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)             errQ <= 1'b0;
    else if (stb.errSet) errQ <= 1'b1;
    else if (stb.errClr) errQ <= 1'b0;
  end

  assign allOn     = modeQ[BIT_OUT] & modeQ[BIT_BYP] & modeQ[BIT_RST];
  assign voteOn    = modeQ[BIT_VOTE_EN];
  assign settleHit = (cntQ == CNT_W'(SETTLE_US - 1));
  assign lockHit   = (cntQ == CNT_W'(LOCK_US - 1));
  assign pollHit   = (cntQ == CNT_W'(POLL_MAX - 1));

  // reset release only after bypass release, at the end of the settle gap (R2, R3)
  p_settle_gap_r3: assert property (@(posedge clk) disable iff (rst)
    stb.relReset |-> (modeQ[BIT_BYP] && settleHit));

  // output opened last (R2)
  p_out_last_r2: assert property (@(posedge clk) disable iff (rst)
    stb.openOut |-> (modeQ[BIT_BYP] && modeQ[BIT_RST]));

  // power-down clears all three control bits in one edge (R8)
  p_shutdown_r8: assert property (@(posedge clk) disable iff (rst)
    stb.shutDown |=> (modeQ[2:0] == 3'b000));

  // timeout only at the final check with the gate still shut (R6)
  p_timeout_r6: assert property (@(posedge clk) disable iff (rst)
    stb.errSet |-> (pollHit && !modeQ[BIT_OUT]));

  // error leaves only through an accepted request (R10)
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    ($fell(errQ) && !$past(rst)) |-> $past(stb.errClr));

endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enReq,
  input  logic       disReq,
  input  logic       usTick,
  input  logic       lockIn,
  input  logic       lockPollSel,
  input  logic       wrEn,
  input  logic       allOn,
  input  logic       voteOn,
  input  logic       settleHit,
  input  logic       lockHit,
  input  logic       pollHit,
  output seqStrobe_t stb,
  output logic       busy
);

  seqState_t stateQ, stateD;

  always_comb begin
    stb    = '0;
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (wrEn) begin
          stb.load = 1'b1;
        end else if (disReq && !voteOn) begin
          stb.shutDown = 1'b1;
          stb.errClr   = 1'b1;
        end else if (enReq && !allOn && !voteOn) begin
          stb.relBypass = 1'b1;
          stb.errClr    = 1'b1;
          stb.cntClr    = 1'b1;
          stateD        = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (usTick) begin
          if (settleHit) begin
            stb.relReset = 1'b1;
            stb.cntClr   = 1'b1;
            stateD       = ST_LOCK;
          end else begin
            stb.cntInc = 1'b1;
          end
        end
      end
      ST_LOCK: begin
        if (usTick) begin
          if (lockPollSel) begin
            if (lockIn) begin
              stb.openOut = 1'b1;
              stateD      = ST_IDLE;
            end else if (pollHit) begin
              stb.errSet = 1'b1;
              stateD     = ST_IDLE;
            end else begin
              stb.cntInc = 1'b1;
            end
          end else if (lockHit) begin
            stb.openOut = 1'b1;
            stateD      = ST_IDLE;
          end else begin
            stb.cntInc = 1'b1;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateD;
  end

  assign busy = (stateQ != ST_IDLE);

  // no write lands while a sequence runs (R9)
  p_no_load_busy_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> !stb.load);

  // voting mode keeps the sequencer idle (R7)
  p_vote_defer_r7: assert property (@(posedge clk) disable iff (rst)
    (!busy && voteOn && !wrEn) |=> !busy);

  // at most one mode-word action per cycle (R2)
  p_one_action_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.load, stb.relBypass, stb.relReset, stb.openOut, stb.shutDown}));

  // busy persists until a finishing strobe (R4, R5, R6)
  p_busy_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && !stb.openOut && !stb.errSet) |=> busy);

endmodule

// File: rtl/pll_pwr_seq.sv
module pll_pwr_seq
  import pll_seq_pkg::*;
#(
  parameter int SETTLE_US = 10,
  parameter int LOCK_US   = 50,
  parameter int POLL_MAX  = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enReq,
  input  logic              disReq,
  input  logic              usTick,
  input  logic              lockIn,
  input  logic              lockPollSel,
  input  logic              wrEn,
  input  logic [MODE_W-1:0] wrData,
  output logic [MODE_W-1:0] modeWord,
  output logic              bypassN,
  output logic              resetN,
  output logic              outEn,
  output logic              busy,
  output logic              timeoutErr
);

  seqStrobe_t stb;
  logic allOn, voteOn, settleHit, lockHit, pollHit;

  pll_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .enReq      (enReq),
    .disReq     (disReq),
    .usTick     (usTick),
    .lockIn     (lockIn),
    .lockPollSel(lockPollSel),
    .wrEn       (wrEn),
    .allOn      (allOn),
    .voteOn     (voteOn),
    .settleHit  (settleHit),
    .lockHit    (lockHit),
    .pollHit    (pollHit),
    .stb        (stb),
    .busy       (busy)
  );

  pll_seq_dp #(
    .SETTLE_US(SETTLE_US),
    .LOCK_US  (LOCK_US),
    .POLL_MAX (POLL_MAX)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .wrData   (wrData),
    .modeQ    (modeWord),
    .errQ     (timeoutErr),
    .allOn    (allOn),
    .voteOn   (voteOn),
    .settleHit(settleHit),
    .lockHit  (lockHit),
    .pollHit  (pollHit)
  );

  assign outEn   = modeWord[BIT_OUT];
  assign bypassN = modeWord[BIT_BYP];
  assign resetN  = modeWord[BIT_RST];

endmodule

// File: tb/pll_pwr_seq_bench.sv
`timescale 1ns/1ps
module pll_pwr_seq_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enReq = 1'b0, disReq = 1'b0, usTick = 1'b0, lockIn = 1'b0;
  logic        lockPollSel = 1'b0, wrEn = 1'b0;
  logic [21:0] wrData = '0;
  logic [21:0] modeWord;
  logic        bypassN, resetN, outEn, busy, timeoutErr;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  pll_pwr_seq u_pll_pwr_seq (
    .clk(clk), .rst(rst), .enReq(enReq), .disReq(disReq), .usTick(usTick),
    .lockIn(lockIn), .lockPollSel(lockPollSel), .wrEn(wrEn), .wrData(wrData),
    .modeWord(modeWord), .bypassN(bypassN), .resetN(resetN), .outEn(outEn),
    .busy(busy), .timeoutErr(timeoutErr)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired: actual cycle %0d expected below 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic pulseEn();
    @(negedge clk) enReq = 1'b1;
    @(negedge clk) enReq = 1'b0;
  endtask

  task automatic pulseDis();
    @(negedge clk) disReq = 1'b1;
    @(negedge clk) disReq = 1'b0;
  endtask

  task automatic writeWord(input logic [21:0] w);
    @(negedge clk) begin wrEn = 1'b1; wrData = w; end
    @(negedge clk) wrEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) usTick = 1'b1;
      @(negedge clk) usTick = 1'b0;
    end
  endtask

  task automatic doReset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 mode word", 32'(modeWord), 0);
    chk("R1 pins", {29'd0, outEn, bypassN, resetN}, 0);
    chk("R1 busy/err", {30'd0, busy, timeoutErr}, 0);
  endtask

  task automatic testTimed();
    lockPollSel = 1'b0;
    lockIn = 1'b1;
    pulseEn();
    chk("R2 bypass released, busy", {29'd0, busy, bypassN, resetN}, 32'b110);
    ticks(9);
    chk("R3 reset still held at tick 9", 32'(resetN), 0);
    ticks(1);
    chk("R3 reset released at tick 10", {30'd0, resetN, outEn}, 32'b10);
    ticks(49);
    chk("R4 lockIn ignored, gate shut at tick 49", {30'd0, outEn, busy}, 32'b01);
    ticks(1);
    chk("R4 gate open at tick 50", {30'd0, outEn, busy}, 32'b10);
    lockIn = 1'b0;
  endtask

  task automatic testAllOnIgnored();
    pulseEn();
    chk("R7 enable ignored when already on", {31'd0, busy}, 0);
  endtask

  task automatic testPoll();
    pulseDis();
    chk("R8 disable clears control bits", 32'(modeWord[2:0]), 0);
    lockPollSel = 1'b1;
    pulseEn();
    ticks(10);
    ticks(5);
    chk("R5 still waiting without lock", {30'd0, busy, outEn}, 32'b10);
    lockIn = 1'b1;
    ticks(1);
    chk("R5 gate open on lock tick", {30'd0, busy, outEn}, 32'b01);
    lockIn = 1'b0;
  endtask

  task automatic testTimeout();
    pulseDis();
    lockPollSel = 1'b1;
    pulseEn();
    ticks(10);
    ticks(199);
    chk("R6 no timeout at check 199", {30'd0, busy, timeoutErr}, 32'b10);
    ticks(1);
    chk("R6 timeout at check 200", {27'd0, busy, timeoutErr, outEn, bypassN, resetN}, 32'b01011);
    ticks(5);
    chk("R10 error sticky", 32'(timeoutErr), 1);
    pulseDis();
    chk("R10 error cleared by accepted request", 32'(timeoutErr), 0);
    pulseEn();
    ticks(210);
    chk("R6 second timeout", 32'(timeoutErr), 1);
    doReset();
    chk("R10 error cleared by reset", {30'd0, timeoutErr, busy}, 0);
  endtask

  task automatic testBusyBlocks();
    lockPollSel = 1'b0;
    pulseEn();
    writeWord(22'h3FFFFF);
    chk("R9 write ignored while busy", 32'(modeWord), 32'h2);
    pulseDis();
    chk("R9 disable ignored while busy", {30'd0, busy, bypassN}, 32'b11);
    ticks(60);
    chk("R9 sequence completes after ignored traffic", 32'(modeWord), 32'h7);
  endtask

  task automatic testFields();
    logic [21:0] f;
    f = (22'd1 << 21) | (22'h15 << 14) | (22'h2A << 8);
    writeWord(f);
    chk("R9 idle write loads word", 32'(modeWord), 32'(f));
    lockPollSel = 1'b0;
    pulseEn();
    ticks(60);
    chk("R11 fields kept through power-up", 32'(modeWord), 32'(f | 22'h7));
    pulseDis();
    chk("R11 fields kept through power-down", 32'(modeWord), 32'(f));
  endtask

  task automatic testVote();
    writeWord(22'd1 << 20);
    pulseEn();
    chk("R7 enable ignored in voting mode", {31'd0, busy}, 0);
    chk("R7 word untouched in voting mode", 32'(modeWord), 32'h100000);
    writeWord((22'd1 << 20) | 22'h7);
    pulseDis();
    chk("R8 disable ignored in voting mode", 32'(modeWord), 32'h100007);
  endtask

  task automatic testWriteWins();
    @(negedge clk) begin wrEn = 1'b1; wrData = '0; enReq = 1'b1; end
    @(negedge clk) begin wrEn = 1'b0; enReq = 1'b0; end
    chk("R9 request dropped under write", {31'd0, busy}, 0);
    chk("R9 write applied", 32'(modeWord), 0);
  endtask

  task automatic testPriority();
    writeWord(22'h7);
    @(negedge clk) begin enReq = 1'b1; disReq = 1'b1; end
    @(negedge clk) begin enReq = 1'b0; disReq = 1'b0; end
    chk("R8 disable wins over enable", {28'd0, busy, modeWord[2:0]}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testTimed();
    testAllOnIgnored();
    testPoll();
    testTimeout();
    testBusyBlocks();
    pulseDis();
    testFields();
    testVote();
    testWriteWins();
    testPriority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule